// File: doc/BRIEF.md
# Centronics Byte Transmitter with Programmable Timing

This block sends single bytes to a printer-style peripheral using the compatibility (Centronics) handshake. When the host writes a byte while the ready flag is high, the block captures it and waits until the peripheral's busy input is low. It then drives the byte onto the data lines with output enable asserted, holds it for a programmed setup interval, pulls strobe low for a programmed width, and keeps the data valid for a programmed hold interval after strobe rises. Unless told to ignore it, the block then waits for the peripheral to pull ack_ low before it is ready for the next byte.

The three intervals come from one 24-bit delay word. Each interval has a 5-bit coarse field and a 3-bit fine field that join into an 8-bit count, coarse in the upper bits, and the interval lasts count+1 clock cycles. At 50 MHz one count is 20 ns and one coarse step is 160 ns. Two option bits choose how the transfer ends: ignore ack_ altogether, or keep the data driven until ack_ arrives. A byte written while a transfer is running is dropped and recorded in a sticky overrun flag.

Top module: `pport_cent_tx`

## Requirements
- R1: After synchronous reset, tr_rdy is 1, strobe_n is 1, pd_oe is 0 and overrun is 0.
- R2: A write (wr_en high) sampled while tr_rdy is 1 captures wr_byte; tr_rdy reads 0 from the next cycle, and when the transfer starts pd_out equals the captured byte with pd_oe at 1.
- R3: The transfer starts (pd_oe rises) only on the clock edge after busy is sampled low; while busy stays high pd_oe stays 0 and strobe_n stays 1.
- R4: The setup count is {dly_cfg[4:0], dly_cfg[7:5]}; pd_oe is 1 with strobe_n at 1 for exactly setup count + 1 cycles before strobe_n falls.
- R5: The strobe count is {dly_cfg[12:8], dly_cfg[15:13]}; strobe_n stays 0 for exactly strobe count + 1 cycles, and pd_oe is 1 whenever strobe_n is 0.
- R6: The hold count is {dly_cfg[20:16], dly_cfg[23:21]}; after strobe_n rises, pd_oe stays 1 and tr_rdy stays 0 for exactly hold count + 1 cycles.
- R7: With ign_ack = 1 the transfer completes at the end of hold: pd_oe falls and tr_rdy rises on the same edge, without regard to ack_n.
- R8: With ign_ack = 0 and oe_ack = 0, pd_oe falls at the end of hold while tr_rdy stays 0 until ack_n is sampled low; tr_rdy reads 1 on the next cycle.
- R9: With ign_ack = 0 and oe_ack = 1, pd_oe stays 1 after hold until ack_n is sampled low, then falls on the same edge that raises tr_rdy.
- R10: When ign_ack and oe_ack are both 1, ign_ack wins and the transfer behaves as in R7.
- R11: A write while tr_rdy is 0 is dropped (pd_out keeps the byte in flight) and sets overrun, which stays 1 until reset.
- R12: pd_out does not change while pd_oe is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock (timing assumes 50 MHz) |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Byte write strobe, one cycle |
| wr_byte | input | 8 | Byte to send |
| dly_cfg | input | 24 | Coarse/fine counts for setup, strobe and hold |
| ign_ack | input | 1 | Complete without waiting for ack_n |
| oe_ack | input | 1 | Keep data driven until ack_n goes low |
| ack_n | input | 1 | Peripheral acknowledge, active low |
| busy | input | 1 | Peripheral busy, active high |
| pd_out | output | 8 | Data lines |
| pd_oe | output | 1 | Output enable for the data lines |
| strobe_n | output | 1 | Data strobe, active low |
| tr_rdy | output | 1 | High when a new byte may be written |
| overrun | output | 1 | Sticky flag: a write was dropped |

## Verification
The in-line assertions watch, on every cycle, that strobe is only low while data is enabled, that the ready flag never coexists with driven data or an active strobe, that data is frozen while enabled, that a transfer never starts on a cycle after busy was high, that overrun never clears, and that the interval counter never wraps below zero. The exact interval lengths, the capture of the right byte, the three ways a transfer can end and the dropping of late writes are only visible across whole transfers, so the bench sweeps coarse and fine values for all three intervals against every option setting and busy delay and counts cycles at the pins against count + 1.

// File: rtl/pport_pkg.sv
package pport_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WAITB = 3'd1,
    ST_SETUP = 3'd2,
    ST_STRB  = 3'd3,
    ST_HOLD  = 3'd4,
    ST_ACKW  = 3'd5
  } cent_state_t;

  // Interval slots in the delay word, low to high
  localparam int IVL_SETUP = 0;
  localparam int IVL_STRB  = 1;
  localparam int IVL_HOLD  = 2;
  localparam int NUM_IVL   = 3;

endpackage

// File: rtl/pport_dly_decode.sv
module pport_dly_decode #(
  parameter int COARSE_W = 5,
  parameter int FINE_W   = 3,
  localparam int CNT_W   = COARSE_W + FINE_W,
  localparam int CFG_W   = pport_pkg::NUM_IVL * CNT_W
) (
  input  logic [CFG_W-1:0]                         dly_cfg,
  output logic [pport_pkg::NUM_IVL-1:0][CNT_W-1:0] ivl_cnt
);

  // Each slot holds coarse in its low bits and fine above it; the count
  // places coarse on top so one coarse step equals 2**FINE_W counts.
  for (genvar i = 0; i < pport_pkg::NUM_IVL; i++) begin : g_ivl
    assign ivl_cnt[i] = {dly_cfg[i*CNT_W +: COARSE_W],
                         dly_cfg[i*CNT_W + COARSE_W +: FINE_W]};
  end

endmodule

// File: rtl/pport_ivl_timer.sv
module pport_ivl_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             cnt_zero
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign cnt_zero = (cnt_q == '0);

  AST_CNT_FLOOR: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt_q == '0) |=> (cnt_q == '0)); // R4

endmodule

// File: rtl/pport_cent_fsm.sv
module pport_cent_fsm
  import pport_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_byte,
  input  logic              busy,
  input  logic              ack_n,
  input  logic              ign_ack,
  input  logic              oe_ack,
  input  logic [CNT_W-1:0]  setup_cnt,
  input  logic [CNT_W-1:0]  strb_cnt,
  input  logic [CNT_W-1:0]  hold_cnt,
  input  logic              tmr_zero,
  output logic              tmr_load,
  output logic [CNT_W-1:0]  tmr_val,
  output logic [DATA_W-1:0] pd_out,
  output logic              pd_oe,
  output logic              strobe_n,
  output logic              tr_rdy,
  output logic              overrun
);

  cent_state_t       st_q, st_d;
  logic [DATA_W-1:0] byte_q;
  logic              oe_d;

  always_comb begin
    st_d     = st_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (st_q)
      ST_IDLE:  if (wr_en) st_d = ST_WAITB;
      ST_WAITB: if (!busy) begin
        st_d     = ST_SETUP;
        tmr_load = 1'b1;
        tmr_val  = setup_cnt;
      end
      ST_SETUP: if (tmr_zero) begin
        st_d     = ST_STRB;
        tmr_load = 1'b1;
        tmr_val  = strb_cnt;
      end
      ST_STRB:  if (tmr_zero) begin
        st_d     = ST_HOLD;
        tmr_load = 1'b1;
        tmr_val  = hold_cnt;
      end
      ST_HOLD:  if (tmr_zero) st_d = ign_ack ? ST_IDLE : ST_ACKW;
      ST_ACKW:  if (!ack_n) st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  // Output enable follows the next state; in the ack wait it keeps the
  // choice made when hold ended.
  always_comb begin
    oe_d = (st_d == ST_SETUP) || (st_d == ST_STRB) || (st_d == ST_HOLD);
    if (st_d == ST_ACKW) oe_d = (st_q == ST_ACKW) ? pd_oe : oe_ack;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_IDLE;
      byte_q   <= '0;
      pd_oe    <= 1'b0;
      strobe_n <= 1'b1;
      tr_rdy   <= 1'b1;
      overrun  <= 1'b0;
    end else begin
      st_q     <= st_d;
      pd_oe    <= oe_d;
      strobe_n <= (st_d != ST_STRB);
      tr_rdy   <= (st_d == ST_IDLE);
      if (st_q == ST_IDLE && wr_en) byte_q <= wr_byte;
      if (st_q != ST_IDLE && wr_en) overrun <= 1'b1;
    end
  end

  assign pd_out = byte_q;

  AST_STRB_NEEDS_OE: assert property (@(posedge clk) disable iff (rst)
    !strobe_n |-> pd_oe); // R5

  AST_RDY_QUIET: assert property (@(posedge clk) disable iff (rst)
    tr_rdy |-> (strobe_n && !pd_oe)); // R2

  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun); // R11

  AST_DATA_FROZEN: assert property (@(posedge clk) disable iff (rst)
    pd_oe |=> (!pd_oe || $stable(pd_out))); // R12

  AST_START_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    $rose(pd_oe) |-> !$past(busy)); // R3

endmodule

// File: rtl/pport_cent_tx.sv
module pport_cent_tx #(
  parameter int DATA_W   = 8,
  parameter int COARSE_W = 5,
  parameter int FINE_W   = 3,
  localparam int CNT_W   = COARSE_W + FINE_W,
  localparam int CFG_W   = pport_pkg::NUM_IVL * CNT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_byte,
  input  logic [CFG_W-1:0]  dly_cfg,
  input  logic              ign_ack,
  input  logic              oe_ack,
  input  logic              ack_n,
  input  logic              busy,
  output logic [DATA_W-1:0] pd_out,
  output logic              pd_oe,
  output logic              strobe_n,
  output logic              tr_rdy,
  output logic              overrun
);

  logic [pport_pkg::NUM_IVL-1:0][CNT_W-1:0] ivl_cnt;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_zero;

  pport_dly_decode #(
    .COARSE_W (COARSE_W),
    .FINE_W   (FINE_W)
  ) u_decode (
    .dly_cfg (dly_cfg),
    .ivl_cnt (ivl_cnt)
  );

  pport_ivl_timer #(
    .CNT_W (CNT_W)
  ) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .cnt_zero (tmr_zero)
  );

  pport_cent_fsm #(
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
  ) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_byte   (wr_byte),
    .busy      (busy),
    .ack_n     (ack_n),
    .ign_ack   (ign_ack),
    .oe_ack    (oe_ack),
    .setup_cnt (ivl_cnt[pport_pkg::IVL_SETUP]),
    .strb_cnt  (ivl_cnt[pport_pkg::IVL_STRB]),
    .hold_cnt  (ivl_cnt[pport_pkg::IVL_HOLD]),
    .tmr_zero  (tmr_zero),
    .tmr_load  (tmr_load),
    .tmr_val   (tmr_val),
    .pd_out    (pd_out),
    .pd_oe     (pd_oe),
    .strobe_n  (strobe_n),
    .tr_rdy    (tr_rdy),
    .overrun   (overrun)
  );

endmodule

// File: tb/pport_cent_tx_tb.sv
module pport_cent_tx_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_byte = '0;
  logic [23:0] dly_cfg = '0;
  logic        ign_ack = 1'b1;
  logic        oe_ack = 1'b0;
  logic        ack_n = 1'b1;
  logic        busy = 1'b0;
  logic [7:0]  pd_out;
  logic        pd_oe, strobe_n, tr_rdy, overrun;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  pport_cent_tx u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_byte(wr_byte),
    .dly_cfg(dly_cfg), .ign_ack(ign_ack), .oe_ack(oe_ack),
    .ack_n(ack_n), .busy(busy), .pd_out(pd_out), .pd_oe(pd_oe),
    .strobe_n(strobe_n), .tr_rdy(tr_rdy), .overrun(overrun)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(tr_rdy == 1'b1, "R1 tr_rdy", tr_rdy, 1);
    chk(strobe_n == 1'b1, "R1 strobe_n", strobe_n, 1);
    chk(pd_oe == 1'b0, "R1 pd_oe", pd_oe, 0);
    chk(overrun == 1'b0, "R1 overrun", overrun, 0);
  endtask

  // One full transfer; counts are coarse*8+fine, intervals last count+1.
  task automatic xfer(input int sc, input int sf, input int mc, input int mf,
                      input int hc, input int hf, input bit ign, input bit oea,
                      input int bcyc, input logic [7:0] b, input bit do_ovr);
    int s_exp, m_exp, h_exp, cnt;
    bit bad;
    s_exp = sc*8 + sf + 1;
    m_exp = mc*8 + mf + 1;
    h_exp = hc*8 + hf + 1;
    dly_cfg = {hf[2:0], hc[4:0], mf[2:0], mc[4:0], sf[2:0], sc[4:0]};
    ign_ack = ign;
    oe_ack = oea;
    busy = (bcyc > 0);
    @(negedge clk);
    chk(tr_rdy == 1'b1, "R2 ready before write", tr_rdy, 1);
    wr_en = 1'b1;
    wr_byte = b;
    @(negedge clk);
    wr_en = 1'b0;
    chk(tr_rdy == 1'b0, "R2 tr_rdy falls", tr_rdy, 0);
    bad = 1'b0;
    for (int k = 0; k < bcyc; k++) begin
      @(negedge clk);
      if (pd_oe !== 1'b0 || strobe_n !== 1'b1) bad = 1'b1;
    end
    chk(!bad, "R3 idle while busy", pd_oe, 0);
    busy = 1'b0;
    @(negedge clk);
    chk(pd_oe == 1'b1, "R3 start after busy low", pd_oe, 1);
    chk(pd_out == b, "R2 captured byte", pd_out, b);
    // setup
    cnt = 1;
    @(negedge clk);
    while (strobe_n == 1'b1 && pd_oe == 1'b1 && cnt < 300) begin
      cnt++;
      @(negedge clk);
    end
    chk(cnt == s_exp, "R4 setup length", cnt, s_exp);
    // strobe
    cnt = 0;
    bad = 1'b0;
    while (strobe_n == 1'b0 && cnt < 300) begin
      if (pd_oe !== 1'b1) bad = 1'b1;
      cnt++;
      if (do_ovr && cnt == 1) begin
        wr_en = 1'b1;
        wr_byte = ~b;
      end else begin
        wr_en = 1'b0;
      end
      @(negedge clk);
    end
    wr_en = 1'b0;
    chk(cnt == m_exp, "R5 strobe length", cnt, m_exp);
    chk(!bad, "R5 oe during strobe", 0, 1);
    if (do_ovr) begin
      chk(overrun == 1'b1, "R11 overrun set", overrun, 1);
      chk(pd_out == b, "R11 late byte dropped", pd_out, b);
    end
    // hold: samples 1..h_exp driven
    bad = 1'b0;
    for (int k = 1; k <= h_exp; k++) begin
      if (pd_oe !== 1'b1 || tr_rdy !== 1'b0 || strobe_n !== 1'b1 || pd_out !== b)
        bad = 1'b1;
      if (k < h_exp) @(negedge clk);
    end
    chk(!bad, "R6 hold window driven", 0, 1);
    @(negedge clk);
    if (ign) begin
      chk(pd_oe == 1'b0, oea ? "R10 oe off at hold end" : "R7 oe off at hold end", pd_oe, 0);
      chk(tr_rdy == 1'b1, oea ? "R10 ready at hold end" : "R7 ready at hold end", tr_rdy, 1);
    end else begin
      chk(pd_oe == oea, oea ? "R9 oe kept after hold" : "R8 oe off after hold", pd_oe, oea);
      chk(tr_rdy == 1'b0, "R8 waits for ack", tr_rdy, 0);
      bad = 1'b0;
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        if (tr_rdy !== 1'b0 || pd_oe !== oea || pd_out !== b) bad = 1'b1;
      end
      chk(!bad, oea ? "R9 oe until ack" : "R8 still waiting", 0, 1);
      ack_n = 1'b0;
      @(negedge clk);
      ack_n = 1'b1;
      chk(tr_rdy == 1'b1, oea ? "R9 ready after ack" : "R8 ready after ack", tr_rdy, 1);
      chk(pd_oe == 1'b0, oea ? "R9 oe off after ack" : "R8 oe off after ack", pd_oe, 0);
    end
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    // spec example setup coarse=2 fine=1 -> count 17
    xfer(2, 1, 0, 0, 0, 0, 1'b1, 1'b0, 0, 8'hA5, 1'b0);
    // sweep fine and coarse values over all modes and busy delays
    for (int c = 0; c < 3; c++) begin
      for (int f = 0; f < 8; f++) begin
        int mode;
        mode = (f + c) % 4;
        xfer(c, f, 2 - c, 7 - f, c, (f + 3) % 8,
             (mode == 0) || (mode == 3), (mode == 2) || (mode == 3),
             f % 3, 8'(c * 37 + f * 11 + 1), 1'b0);
      end
    end
    // overrun during strobe, then verify sticky over the next transfer
    xfer(0, 2, 0, 3, 0, 1, 1'b0, 1'b0, 1, 8'h3C, 1'b1);
    xfer(0, 1, 0, 1, 0, 1, 1'b1, 1'b0, 0, 8'hC3, 1'b0);
    chk(overrun == 1'b1, "R11 overrun sticky", overrun, 1);
    chk(pd_out == 8'hC3, "R12 next byte sent", pd_out, 8'hC3);
    // maximum counts
    xfer(31, 7, 31, 7, 31, 7, 1'b0, 1'b1, 2, 8'hFF, 1'b0);
    do_reset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule